// File: doc/BRIEF.md
# UART Flow Controller

This block governs the data flow of one serial channel. It sits between a transmitter, a receiver and a receive FIFO, and it holds none of their datapath. In hardware mode it gates the transmitter with an active-low clear-to-send input. It also drives an active-low request-to-send output from the receive FIFO fill level, using a high and a low threshold with hysteresis.

In software mode it checks every received byte against programmed resume and pause characters. Each of these is either one byte or a pair of bytes that must arrive back to back. A matched control character pauses or resumes the transmitter and never reaches the FIFO. When the FIFO fills, the block asks the transmitter to insert the pause character or pair. When the FIFO has drained, it asks for the resume character or pair. Each crossing produces one request.

A pause, from either source, takes effect only between characters. The transmitter reports a character in progress with `tx_active` and its final stop-bit cycle with `tx_char_done`. A remap control moves the handshake onto the data-set-ready input and the data-terminal-ready output. Received bytes must arrive at least two clock cycles apart.

Top module: `ufc_flow_ctrl`

## Requirements
- R1: While `tx_active` is 1 and `tx_char_done` is 0, `tx_allow` does not change. It is re-evaluated at each clock edge where `tx_active` is 0 or `tx_char_done` is 1.
- R2: With `hw_en`=1, a 1 on the selected clear-to-send line drives `tx_allow` to 0 at the next evaluation edge. A 0 on that line drives `tx_allow` back to 1.
- R3: With `remap_en`=1, `dsr_n` replaces `cts_n`, `dtr_n` carries the request-to-send level and `rts_n` is held at 1. With `remap_en`=0, `dtr_n` is held at 1.
- R4: With `hw_en`=1, the request-to-send line goes to 1 one cycle after `fifo_level` >= `thr_hi`. It returns to 0 only one cycle after `fifo_level` <= `thr_lo`. With `hw_en`=0 the line is 0.
- R5: With `sw_en`=1 and `dual_en`=0, a byte equal to `xoff1` pauses the transmitter and a byte equal to `xon1` resumes it. Neither byte is written to the FIFO. Any other byte is written one cycle after its strobe.
- R6: With `sw_en`=1 and `dual_en`=1, the pair `xoff1`,`xoff2` received consecutively pauses the transmitter and the pair `xon1`,`xon2` resumes it. Neither byte of a matched pair is written.
- R7: In pair mode, a buffered first byte followed by a byte that does not complete the pair is written first. The new byte follows on the next cycle, unless the new byte itself starts a pair, in which case it is buffered.
- R8: With `sw_en`=1, when `fifo_level` reaches `thr_hi` the block raises `ins_valid` with `xoff1`, then `xoff2` in pair mode. The request is made once per crossing.
- R9: After a pause request has been acknowledged, the block requests `xon1` (then `xon2` in pair mode) once `fifo_level` <= `thr_lo`.
- R10: With `sw_en`=0 every received byte, including control characters, is written unchanged one cycle after its strobe, and software pausing is inactive.
- R11: After reset `tx_allow`=1, `rts_n`=0, `dtr_n`=1, `ins_valid`=0 and `fifo_wr`=0.
- R12: An insertion request keeps `ins_valid` at 1 and `ins_char` unchanged until `ins_ack` is 1. The request advances at the edge where `ins_ack` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hw_en | input | 1 | Hardware handshake enable |
| sw_en | input | 1 | Character-based flow control enable |
| dual_en | input | 1 | Control characters are byte pairs |
| remap_en | input | 1 | Move handshake to dsr_n/dtr_n |
| thr_hi | input | LVL_W | FIFO level that stops the remote sender |
| thr_lo | input | LVL_W | FIFO level that restarts the remote sender |
| xon1 | input | 8 | Resume character, first byte |
| xon2 | input | 8 | Resume character, second byte |
| xoff1 | input | 8 | Pause character, first byte |
| xoff2 | input | 8 | Pause character, second byte |
| fifo_level | input | LVL_W | Receive FIFO fill level |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| fifo_wr | output | 1 | Write strobe to the receive FIFO |
| fifo_data | output | 8 | Byte written to the receive FIFO |
| tx_active | input | 1 | Transmitter is shifting a character |
| tx_char_done | input | 1 | Last stop-bit cycle of the current character |
| tx_allow | output | 1 | Transmitter may start a data character |
| ins_valid | output | 1 | Request to insert a control character |
| ins_char | output | 8 | Control character to insert |
| ins_ack | input | 1 | Transmitter took the control character |
| cts_n | input | 1 | Clear-to-send, active low |
| dsr_n | input | 1 | Data-set-ready, active low |
| rts_n | output | 1 | Request-to-send, active low |
| dtr_n | output | 1 | Data-terminal-ready, active low |

## Verification
The checker tests on every cycle the properties that hold at every edge:
- the transmit permission is frozen while a character is in flight;
- the remap keeps the unused handshake output inactive;
- request-to-send goes high one cycle after the high threshold is met;
- control characters are dropped and data passes through when software mode is off;
- an insertion request holds until it is acknowledged.

Only the bench's scenarios can show behaviour that spans sequences:
- pair matching with a mismatched second byte, and the replay order that follows;
- the hysteresis band;
- the pause-then-resume insertion sequence, made once per crossing.

// File: rtl/ufc_pkg.sv
package ufc_pkg;
    localparam int CHAR_W = 8;

    typedef logic [CHAR_W-1:0] char_t;

    typedef struct packed {
        char_t on1;
        char_t on2;
        char_t off1;
        char_t off2;
    } fc_chars_t;

    typedef enum logic {SEQ_XOFF = 1'b0, SEQ_XON = 1'b1} seq_kind_e;

    // Pick the control character for a sequence kind and byte index.
    function automatic char_t sel_char(fc_chars_t c, seq_kind_e k, logic second);
        if (k == SEQ_XON) return second ? c.on2 : c.on1;
        return second ? c.off2 : c.off1;
    endfunction
endpackage

// File: rtl/ufc_level_mon.sv
module ufc_level_mon #(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] hi,
    input  logic [LVL_W-1:0] lo,
    output logic             above
);
    always_ff @(posedge clk) begin
        if (rst)              above <= 1'b0;
        else if (level >= hi) above <= 1'b1;
        else if (level <= lo) above <= 1'b0;
    end
endmodule

// File: rtl/ufc_ins_seq.sv
module ufc_ins_seq
    import ufc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sw_en,
    input  logic      dual_en,
    input  logic      above,
    input  fc_chars_t chars,
    input  logic      ack,
    output logic      req,
    output char_t     req_char
);
    logic      busy, idx, off_sent;
    seq_kind_e kind;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            idx      <= 1'b0;
            off_sent <= 1'b0;
            kind     <= SEQ_XOFF;
        end else if (busy) begin
            if (ack) begin
                if (dual_en && !idx) begin
                    idx <= 1'b1;
                end else begin
                    busy     <= 1'b0;
                    idx      <= 1'b0;
                    off_sent <= (kind == SEQ_XOFF);
                end
            end
        end else if (sw_en && above && !off_sent) begin
            busy <= 1'b1;
            kind <= SEQ_XOFF;
        end else if (!above && off_sent) begin
            busy <= 1'b1;
            kind <= SEQ_XON;
        end
    end

    assign req      = busy;
    assign req_char = sel_char(chars, kind, idx);
endmodule

// File: rtl/ufc_rx_filter.sv
module ufc_rx_filter
    import ufc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      sw_en,
    input  logic      dual_en,
    input  fc_chars_t chars,
    input  logic      in_valid,
    input  char_t     in_byte,
    output logic      out_wr,
    output char_t     out_byte,
    output logic      remote_stop
);
    logic      pend_v, replay_v, paused;
    char_t     pend_b, replay_b;
    seq_kind_e pend_k;
    char_t     second;

    assign second = sel_char(chars, pend_k, 1'b1);

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_v   <= 1'b0;
            pend_b   <= '0;
            pend_k   <= SEQ_XOFF;
            replay_v <= 1'b0;
            replay_b <= '0;
            paused   <= 1'b0;
            out_wr   <= 1'b0;
            out_byte <= '0;
        end else begin
            out_wr <= 1'b0;
            if (!sw_en) begin
                paused <= 1'b0;
                pend_v <= 1'b0;
            end
            if (replay_v) begin
                out_wr   <= 1'b1;
                out_byte <= replay_b;
                replay_v <= 1'b0;
            end
            if (in_valid) begin
                if (!sw_en) begin
                    out_wr   <= 1'b1;
                    out_byte <= in_byte;
                end else if (!dual_en) begin
                    if (in_byte == chars.off1)     paused <= 1'b1;
                    else if (in_byte == chars.on1) paused <= 1'b0;
                    else begin
                        out_wr   <= 1'b1;
                        out_byte <= in_byte;
                    end
                end else if (pend_v && in_byte == second) begin
                    paused <= (pend_k == SEQ_XOFF);
                    pend_v <= 1'b0;
                end else begin
                    if (pend_v) begin
                        out_wr   <= 1'b1;
                        out_byte <= pend_b;
                    end
                    if (in_byte == chars.off1 || in_byte == chars.on1) begin
                        pend_v <= 1'b1;
                        pend_b <= in_byte;
                        pend_k <= (in_byte == chars.off1) ? SEQ_XOFF : SEQ_XON;
                    end else begin
                        pend_v <= 1'b0;
                        if (pend_v) begin
                            replay_v <= 1'b1;
                            replay_b <= in_byte;
                        end else begin
                            out_wr   <= 1'b1;
                            out_byte <= in_byte;
                        end
                    end
                end
            end
        end
    end

    assign remote_stop = paused;
endmodule

// File: rtl/ufc_tx_gate.sv
module ufc_tx_gate (
    input  logic clk,
    input  logic rst,
    input  logic hw_en,
    input  logic remap_en,
    input  logic cts_n,
    input  logic dsr_n,
    input  logic remote_stop,
    input  logic busy,
    input  logic boundary,
    output logic allow
);
    logic clear_n;

    assign clear_n = remap_en ? dsr_n : cts_n;

    always_ff @(posedge clk) begin
        if (rst)                   allow <= 1'b1;
        else if (!busy || boundary) allow <= !((hw_en && clear_n) || remote_stop);
    end
endmodule

// File: rtl/ufc_flow_ctrl.sv
module ufc_flow_ctrl
    import ufc_pkg::*;
#(
    parameter int LVL_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hw_en,
    input  logic             sw_en,
    input  logic             dual_en,
    input  logic             remap_en,
    input  logic [LVL_W-1:0] thr_hi,
    input  logic [LVL_W-1:0] thr_lo,
    input  logic [7:0]       xon1,
    input  logic [7:0]       xon2,
    input  logic [7:0]       xoff1,
    input  logic [7:0]       xoff2,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             rx_valid,
    input  logic [7:0]       rx_byte,
    output logic             fifo_wr,
    output logic [7:0]       fifo_data,
    input  logic             tx_active,
    input  logic             tx_char_done,
    output logic             tx_allow,
    output logic             ins_valid,
    output logic [7:0]       ins_char,
    input  logic             ins_ack,
    input  logic             cts_n,
    input  logic             dsr_n,
    output logic             rts_n,
    output logic             dtr_n
);
    fc_chars_t chars;
    logic      above, remote_stop, flow_n;

    assign chars = '{on1: xon1, on2: xon2, off1: xoff1, off2: xoff2};

    ufc_level_mon #(.LVL_W(LVL_W)) u_level (
        .clk(clk), .rst(rst), .level(fifo_level),
        .hi(thr_hi), .lo(thr_lo), .above(above)
    );

    ufc_rx_filter u_filter (
        .clk(clk), .rst(rst), .sw_en(sw_en), .dual_en(dual_en),
        .chars(chars), .in_valid(rx_valid), .in_byte(rx_byte),
        .out_wr(fifo_wr), .out_byte(fifo_data), .remote_stop(remote_stop)
    );

    ufc_ins_seq u_ins (
        .clk(clk), .rst(rst), .sw_en(sw_en), .dual_en(dual_en),
        .above(above), .chars(chars), .ack(ins_ack),
        .req(ins_valid), .req_char(ins_char)
    );

    ufc_tx_gate u_gate (
        .clk(clk), .rst(rst), .hw_en(hw_en), .remap_en(remap_en),
        .cts_n(cts_n), .dsr_n(dsr_n), .remote_stop(remote_stop),
        .busy(tx_active), .boundary(tx_char_done), .allow(tx_allow)
    );

    assign flow_n = hw_en && above;
    assign rts_n  = remap_en ? 1'b1 : flow_n;
    assign dtr_n  = remap_en ? flow_n : 1'b1;
endmodule

// File: rtl/ufc_flow_ctrl_chk.sv
module ufc_flow_ctrl_chk #(
    parameter int LVL_W = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             hw_en,
    input logic             sw_en,
    input logic             dual_en,
    input logic             remap_en,
    input logic [LVL_W-1:0] thr_hi,
    input logic [7:0]       xon1,
    input logic [7:0]       xoff1,
    input logic [LVL_W-1:0] fifo_level,
    input logic             rx_valid,
    input logic [7:0]       rx_byte,
    input logic             fifo_wr,
    input logic [7:0]       fifo_data,
    input logic             tx_active,
    input logic             tx_char_done,
    input logic             tx_allow,
    input logic             ins_valid,
    input logic [7:0]       ins_char,
    input logic             ins_ack,
    input logic             rts_n,
    input logic             dtr_n
);
    p_hold_mid_char_r1: assert property (@(posedge clk) disable iff (rst)
        (tx_active && !tx_char_done) |=> $stable(tx_allow));

    p_remap_rts_idle_r3: assert property (@(posedge clk) disable iff (rst)
        remap_en |-> rts_n);

    p_plain_dtr_idle_r3: assert property (@(posedge clk) disable iff (rst)
        !remap_en |-> dtr_n);

    p_rts_high_thr_r4: assert property (@(posedge clk) disable iff (rst)
        (hw_en && !remap_en && fifo_level >= thr_hi) |=> (rts_n || !hw_en || remap_en));

    p_single_drop_r5: assert property (@(posedge clk) disable iff (rst)
        (sw_en && !dual_en && rx_valid && (rx_byte == xon1 || rx_byte == xoff1)) |=> !fifo_wr);

    p_passthru_r10: assert property (@(posedge clk) disable iff (rst)
        (!sw_en && rx_valid) |=> (fifo_wr && fifo_data == $past(rx_byte)));

    p_req_hold_r12: assert property (@(posedge clk) disable iff (rst)
        (ins_valid && !ins_ack) |=> (ins_valid && $stable(ins_char)));
endmodule

bind ufc_flow_ctrl ufc_flow_ctrl_chk #(.LVL_W(LVL_W)) u_chk (
    .clk(clk), .rst(rst), .hw_en(hw_en), .sw_en(sw_en), .dual_en(dual_en),
    .remap_en(remap_en), .thr_hi(thr_hi), .xon1(xon1), .xoff1(xoff1),
    .fifo_level(fifo_level), .rx_valid(rx_valid), .rx_byte(rx_byte),
    .fifo_wr(fifo_wr), .fifo_data(fifo_data), .tx_active(tx_active),
    .tx_char_done(tx_char_done), .tx_allow(tx_allow), .ins_valid(ins_valid),
    .ins_char(ins_char), .ins_ack(ins_ack), .rts_n(rts_n), .dtr_n(dtr_n)
);

// File: tb/ufc_flow_ctrl_tb.sv
module ufc_flow_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LVL_W = 8;
    localparam int NVEC = 11;

    // {rx byte, write count, first write, second write, expected tx_allow}
    localparam logic [26:0] VEC [NVEC] = '{
        {8'h41, 2'd1, 8'h41, 8'h00, 1'b1},
        {8'h13, 2'd0, 8'h00, 8'h00, 1'b1},
        {8'h33, 2'd0, 8'h00, 8'h00, 1'b0},
        {8'h11, 2'd0, 8'h00, 8'h00, 1'b0},
        {8'h41, 2'd2, 8'h11, 8'h41, 1'b0},
        {8'h11, 2'd0, 8'h00, 8'h00, 1'b0},
        {8'h22, 2'd0, 8'h00, 8'h00, 1'b1},
        {8'h13, 2'd0, 8'h00, 8'h00, 1'b1},
        {8'h11, 2'd1, 8'h13, 8'h00, 1'b1},
        {8'h22, 2'd0, 8'h00, 8'h00, 1'b1},
        {8'h33, 2'd1, 8'h33, 8'h00, 1'b1}
    };

    logic clk = 0, rst = 1;
    logic hw_en = 0, sw_en = 0, dual_en = 0, remap_en = 0;
    logic [LVL_W-1:0] thr_hi = 8'd10, thr_lo = 8'd4, fifo_level = 0;
    logic [7:0] xon1 = 8'h11, xon2 = 8'h22, xoff1 = 8'h13, xoff2 = 8'h33;
    logic rx_valid = 0;
    logic [7:0] rx_byte = 0;
    logic fifo_wr, tx_allow, ins_valid, rts_n, dtr_n;
    logic [7:0] fifo_data, ins_char;
    logic tx_active = 0, tx_char_done = 0, ins_ack = 0, cts_n = 0, dsr_n = 0;

    int errors = 0, checks = 0;
    int nw;
    logic [7:0] w0, w1;

    always #(CLK_PERIOD/2) clk = ~clk;

    ufc_flow_ctrl #(.LVL_W(LVL_W)) u_dut (
        .clk(clk), .rst(rst), .hw_en(hw_en), .sw_en(sw_en), .dual_en(dual_en),
        .remap_en(remap_en), .thr_hi(thr_hi), .thr_lo(thr_lo), .xon1(xon1),
        .xon2(xon2), .xoff1(xoff1), .xoff2(xoff2), .fifo_level(fifo_level),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .fifo_wr(fifo_wr),
        .fifo_data(fifo_data), .tx_active(tx_active), .tx_char_done(tx_char_done),
        .tx_allow(tx_allow), .ins_valid(ins_valid), .ins_char(ins_char),
        .ins_ack(ins_ack), .cts_n(cts_n), .dsr_n(dsr_n), .rts_n(rts_n), .dtr_n(dtr_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Drive one byte and collect FIFO writes over the two following cycles.
    task automatic send(input logic [7:0] b);
        rx_byte = b; rx_valid = 1;
        @(negedge clk);
        rx_valid = 0;
        nw = 0; w0 = 0; w1 = 0;
        for (int i = 0; i < 2; i++) begin
            if (fifo_wr) begin
                if (nw == 0) w0 = fifo_data; else w1 = fifo_data;
                nw++;
            end
            @(negedge clk);
        end
    endtask

    task automatic ack();
        ins_ack = 1;
        @(negedge clk);
        ins_ack = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        tick(3);
        rst = 0;
        tick(1);
        chk("R11 tx_allow", tx_allow, 1);
        chk("R11 rts_n", rts_n, 0);
        chk("R11 dtr_n", dtr_n, 1);
        chk("R11 ins_valid", ins_valid, 0);
        chk("R11 fifo_wr", fifo_wr, 0);

        // R10: software mode off, control byte passes as data
        send(8'h13);
        chk("R10 count", nw, 1);
        chk("R10 data", w0, 8'h13);
        chk("R10 allow", tx_allow, 1);

        // R6/R7 pair-mode table
        sw_en = 1; dual_en = 1;
        for (int v = 0; v < NVEC; v++) begin
            send(VEC[v][26:19]);
            tick(1);
            chk($sformatf("R6/R7 vec%0d count", v), nw, VEC[v][18:17]);
            if (VEC[v][18:17] > 0) chk($sformatf("R7 vec%0d first", v), w0, VEC[v][16:9]);
            if (VEC[v][18:17] > 1) chk($sformatf("R7 vec%0d second", v), w1, VEC[v][8:1]);
            chk($sformatf("R6 vec%0d allow", v), tx_allow, VEC[v][0]);
        end

        // R5 single-character mode
        dual_en = 0;
        send(8'h13); tick(1);
        chk("R5 xoff dropped", nw, 0);
        chk("R5 paused", tx_allow, 0);
        send(8'h11); tick(1);
        chk("R5 xon dropped", nw, 0);
        chk("R5 resumed", tx_allow, 1);
        send(8'h55);
        chk("R5 data count", nw, 1);
        chk("R5 data", w0, 8'h55);
        sw_en = 0;

        // R1/R2 clear-to-send at a character boundary
        hw_en = 1;
        tx_active = 1; cts_n = 1;
        tick(3);
        chk("R1 held mid-char", tx_allow, 1);
        tx_char_done = 1;
        tick(1);
        tx_char_done = 0; tx_active = 0;
        chk("R2 stopped at boundary", tx_allow, 0);
        cts_n = 0;
        tick(1);
        chk("R2 resumed", tx_allow, 1);

        // R3 remap
        remap_en = 1; cts_n = 1; dsr_n = 0;
        tick(1);
        chk("R3 cts ignored", tx_allow, 1);
        dsr_n = 1;
        tick(1);
        chk("R3 dsr stops", tx_allow, 0);
        dsr_n = 0; cts_n = 0;
        fifo_level = 12;
        tick(1);
        chk("R3 dtr high", dtr_n, 1);
        chk("R3 rts idle", rts_n, 1);
        fifo_level = 0;
        tick(1);
        chk("R3 dtr low", dtr_n, 0);
        chk("R3 rts idle low lvl", rts_n, 1);
        remap_en = 0;

        // R4 hysteresis
        fifo_level = 9;  tick(1); chk("R4 below hi", rts_n, 0);
        fifo_level = 10; tick(1); chk("R4 at hi", rts_n, 1);
        fifo_level = 6;  tick(1); chk("R4 in band", rts_n, 1);
        fifo_level = 4;  tick(1); chk("R4 at lo", rts_n, 0);
        hw_en = 0;
        tick(1);
        chk("R4 disabled", rts_n, 0);

        // R8/R9/R12 pair insertion
        sw_en = 1; dual_en = 1;
        fifo_level = 12;
        tick(2);
        chk("R8 req", ins_valid, 1);
        chk("R8 first", ins_char, 8'h13);
        tick(2);
        chk("R12 held", ins_char, 8'h13);
        ack();
        chk("R8 second valid", ins_valid, 1);
        chk("R8 second", ins_char, 8'h33);
        ack();
        chk("R8 done", ins_valid, 0);
        tick(3);
        chk("R8 once", ins_valid, 0);
        fifo_level = 3;
        tick(2);
        chk("R9 req", ins_valid, 1);
        chk("R9 first", ins_char, 8'h11);
        ack();
        chk("R9 second", ins_char, 8'h22);
        ack();
        chk("R9 done", ins_valid, 0);

        // R8/R9 single-character insertion
        dual_en = 0;
        fifo_level = 12;
        tick(2);
        chk("R8 single", ins_char, 8'h13);
        ack();
        chk("R8 single done", ins_valid, 0);
        fifo_level = 0;
        tick(2);
        chk("R9 single", ins_char, 8'h11);
        ack();
        chk("R9 single done", ins_valid, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule